// File: doc/BRIEF.md
# Accumulator Processor Core

A small 16-bit stored-program processor built around a single accumulator. Code and data share one external memory, reached through a 12-bit address bus and separate 16-bit read and write data buses. A request strobe qualifies each access, and a direction line selects between read and write.

Each instruction word carries an opcode in its top four bits and a memory address in the low twelve bits. An instruction takes one clock cycle per memory access it makes, so every instruction finishes in one or two cycles. The read of the next instruction is folded into the last cycle of the current one. The ALU does double duty. It combines operands with the accumulator, and in fetch cycles it also computes the address plus one that goes into the program counter.

Every internal register updates on the falling clock edge. Memory is expected to return read data within the same cycle as the request.

Top module: `tc_accum_core`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, the bus shows a read at address 0 (the `RESET_VEC` default). Reset also clears the accumulator, so `mem_wdata` reads 0.
- R2: Bits 15:12 of an instruction hold the opcode and bits 11:0 hold the operand address. The codes are: 0 load, 1 store, 2 add, 3 subtract, 4 jump, 5 jump if the accumulator is non-negative, 6 jump if the accumulator is non-zero, 7 stop.
- R3: Load, add and subtract each take two cycles. The first cycle reads the operand address and sets the accumulator to the word read, to the sum, or to the difference (accumulator minus word). Results wrap modulo 2^16.
- R4: Store takes two cycles. The first cycle writes the accumulator to the operand address.
- R5: An unconditional jump takes one cycle, and that cycle reads the next instruction from the operand address.
- R6: The non-negative jump is taken when accumulator bit 15 is 0. When it is not taken, its single cycle fetches from the program counter instead.
- R7: The non-zero jump is taken when the accumulator is not all zeros. When it is not taken, it fetches from the program counter.
- R8: Opcodes 7 through 15 stop the core. From the cycle after the stop word is fetched, `mem_req` stays low until reset.
- R9: While running, `mem_req` is high in every cycle. The cycle after the operand access of a two-cycle instruction fetches from the program counter.
- R10: Every instruction fetch leaves the program counter holding the fetch address plus one, so code after a jump target runs in sequence.
- R11: A word written by a store can later be fetched and executed as an instruction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; registers update on its falling edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 12 | Memory address for the current cycle |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the request |
| mem_wdata | output | 16 | Write data (the accumulator) |
| mem_req | output | 1 | Memory access request for this cycle |
| mem_rd | output | 1 | 1 = read, 0 = write; meaningful when `mem_req` is high |

## Verification
The checker assumes that `rst` is held for at least one falling edge, and that memory answers a read combinationally before the next falling edge, so a fetched word is settled when the instruction register loads. It also assumes the bus outputs are only meaningful while `mem_req` is high. The stimulus changes `rst` a little after a falling edge. The bench memory serves reads directly from its array and commits writes on the falling edge. Programs stay inside the bench's 256-word memory, so every address the core issues maps to a real word.

// File: rtl/tc_core_pkg.sv
`timescale 1ns/1ps
package tc_core_pkg;

    localparam int DATA_W = 16;
    localparam int ADDR_W = 12;
    localparam int OPC_W  = 4;
    localparam int PAD_W  = DATA_W - ADDR_W;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [OPC_W-1:0]  opc_t;

    typedef enum logic [OPC_W-1:0] {
        OP_LOAD  = 4'd0,
        OP_STORE = 4'd1,
        OP_ADD   = 4'd2,
        OP_SUB   = 4'd3,
        OP_JUMP  = 4'd4,
        OP_JGE   = 4'd5,
        OP_JNZ   = 4'd6,
        OP_STOP  = 4'd7
    } opcode_e;

    typedef struct packed {
        opc_t  opc;
        addr_t operand;
    } instr_t;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_EXEC,
        ST_FETCH,
        ST_HALT
    } state_e;

    typedef enum logic [1:0] {
        ALU_PASS,
        ALU_ADD,
        ALU_SUB,
        ALU_INC
    } alu_op_e;

    typedef enum logic [1:0] {
        ASRC_PC,
        ASRC_IR,
        ASRC_VEC
    } addr_src_e;

    // Datapath steering produced by the sequencer each cycle
    typedef struct packed {
        addr_src_e addr_src;
        logic      opnd_is_addr;
        alu_op_e   alu_op;
        logic      acc_en;
        logic      pc_en;
        logic      ir_en;
    } ctrl_t;

    function automatic instr_t split_instr(word_t w);
        return instr_t'(w);
    endfunction

    function automatic logic is_jump(opc_t opc);
        return (opc == OP_JUMP) || (opc == OP_JGE) || (opc == OP_JNZ);
    endfunction

    function automatic logic jump_taken(opc_t opc, logic acc_zero, logic acc_neg);
        logic t;
        t = 1'b0;
        if (opc == OP_JUMP) t = 1'b1;
        if (opc == OP_JGE)  t = ~acc_neg;
        if (opc == OP_JNZ)  t = ~acc_zero;
        return t;
    endfunction

    function automatic alu_op_e alu_for(opc_t opc);
        alu_op_e r;
        case (opc)
            OP_ADD:  r = ALU_ADD;
            OP_SUB:  r = ALU_SUB;
            default: r = ALU_PASS;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tc_alu.sv
`timescale 1ns/1ps
module tc_alu
    import tc_core_pkg::*;
(
    input  alu_op_e op,
    input  word_t   a,
    input  word_t   b,
    output word_t   y
);

    always_comb begin
        unique case (op)
            ALU_PASS: y = b;
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_INC:  y = a + word_t'(1);
            default:  y = b;
        endcase
    end

endmodule

// File: rtl/tc_ctrl.sv
`timescale 1ns/1ps
module tc_ctrl
    import tc_core_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  opc_t   opc,
    input  logic   acc_zero,
    input  logic   acc_neg,
    output ctrl_t  ctl,
    output logic   mem_req,
    output logic   mem_rd
);

    state_e    state_q;
    state_e    state_d;
    logic      do_fetch;
    addr_src_e fetch_src;

    always_comb begin
        state_d          = state_q;
        do_fetch         = 1'b0;
        fetch_src        = ASRC_PC;
        mem_req          = 1'b0;
        mem_rd           = 1'b1;
        ctl.addr_src     = ASRC_PC;
        ctl.opnd_is_addr = 1'b0;
        ctl.alu_op       = ALU_PASS;
        ctl.acc_en       = 1'b0;
        ctl.pc_en        = 1'b0;
        ctl.ir_en        = 1'b0;

        unique case (state_q)
            ST_BOOT: begin
                do_fetch  = 1'b1;
                fetch_src = ASRC_VEC;
                state_d   = ST_EXEC;
            end
            ST_FETCH: begin
                do_fetch  = 1'b1;
                fetch_src = ASRC_PC;
                state_d   = ST_EXEC;
            end
            ST_EXEC: begin
                if (opc == OP_LOAD || opc == OP_ADD || opc == OP_SUB) begin
                    mem_req      = 1'b1;
                    mem_rd       = 1'b1;
                    ctl.addr_src = ASRC_IR;
                    ctl.alu_op   = alu_for(opc);
                    ctl.acc_en   = 1'b1;
                    state_d      = ST_FETCH;
                end else if (opc == OP_STORE) begin
                    mem_req      = 1'b1;
                    mem_rd       = 1'b0;
                    ctl.addr_src = ASRC_IR;
                    state_d      = ST_FETCH;
                end else if (is_jump(opc)) begin
                    do_fetch  = 1'b1;
                    fetch_src = jump_taken(opc, acc_zero, acc_neg) ? ASRC_IR : ASRC_PC;
                    state_d   = ST_EXEC;
                end else begin
                    state_d = ST_HALT;
                end
            end
            ST_HALT: begin
                state_d = ST_HALT;
            end
            default: begin
                state_d = ST_HALT;
            end
        endcase

        // Shared fetch: read next word, ALU forms address + 1 for the PC
        if (do_fetch) begin
            mem_req          = 1'b1;
            mem_rd           = 1'b1;
            ctl.addr_src     = fetch_src;
            ctl.opnd_is_addr = 1'b1;
            ctl.alu_op       = ALU_INC;
            ctl.pc_en        = 1'b1;
            ctl.ir_en        = 1'b1;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) state_q <= ST_BOOT;
        else     state_q <= state_d;
    end

endmodule

// File: rtl/tc_datapath.sv
`timescale 1ns/1ps
module tc_datapath
    import tc_core_pkg::*;
#(
    parameter addr_t RESET_VEC = '0
)(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctl,
    input  word_t mem_rdata,
    output addr_t mem_addr,
    output word_t mem_wdata,
    output logic  acc_zero,
    output logic  acc_neg,
    output opc_t  opc,
    output addr_t ir_addr,
    output addr_t pc_val
);

    word_t  acc_q;
    word_t  ir_q;
    addr_t  pc_q;
    word_t  alu_a;
    word_t  alu_y;
    instr_t ir_f;

    assign ir_f = split_instr(ir_q);

    always_comb begin
        unique case (ctl.addr_src)
            ASRC_PC:  mem_addr = pc_q;
            ASRC_IR:  mem_addr = ir_f.operand;
            default:  mem_addr = RESET_VEC;
        endcase
    end

    assign alu_a = ctl.opnd_is_addr ? {{PAD_W{1'b0}}, mem_addr} : acc_q;

    tc_alu u_alu (
        .op (ctl.alu_op),
        .a  (alu_a),
        .b  (mem_rdata),
        .y  (alu_y)
    );

    always_ff @(negedge clk) begin
        if (rst) begin
            acc_q <= '0;
            pc_q  <= RESET_VEC;
            ir_q  <= '0;
        end else begin
            if (ctl.acc_en) acc_q <= alu_y;
            if (ctl.pc_en)  pc_q  <= alu_y[ADDR_W-1:0];
            if (ctl.ir_en)  ir_q  <= mem_rdata;
        end
    end

    assign mem_wdata = acc_q;
    assign acc_zero  = (acc_q == '0);
    assign acc_neg   = acc_q[DATA_W-1];
    assign opc       = ir_f.opc;
    assign ir_addr   = ir_f.operand;
    assign pc_val    = pc_q;

endmodule

// File: rtl/tc_accum_core.sv
`timescale 1ns/1ps
module tc_accum_core
    import tc_core_pkg::*;
#(
    parameter logic [11:0] RESET_VEC = 12'h000
)(
    input  logic        clk,
    input  logic        rst,
    output logic [11:0] mem_addr,
    input  logic [15:0] mem_rdata,
    output logic [15:0] mem_wdata,
    output logic        mem_req,
    output logic        mem_rd
);

    ctrl_t ctl;
    opc_t  opc;
    logic  acc_zero;
    logic  acc_neg;
    addr_t ir_addr;
    addr_t pc_val;
    logic  ir_load;

    tc_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .opc      (opc),
        .acc_zero (acc_zero),
        .acc_neg  (acc_neg),
        .ctl      (ctl),
        .mem_req  (mem_req),
        .mem_rd   (mem_rd)
    );

    tc_datapath #(.RESET_VEC(RESET_VEC)) u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .acc_zero  (acc_zero),
        .acc_neg   (acc_neg),
        .opc       (opc),
        .ir_addr   (ir_addr),
        .pc_val    (pc_val)
    );

    assign ir_load = ctl.ir_en;

endmodule

// File: rtl/tc_accum_core_chk.sv
`timescale 1ns/1ps
module tc_accum_core_chk #(
    parameter logic [11:0] RESET_VEC = 12'h000
)(
    input logic        clk,
    input logic        rst,
    input logic [11:0] mem_addr,
    input logic        mem_req,
    input logic        mem_rd,
    input logic        ir_load,
    input logic [11:0] ir_addr,
    input logic [11:0] pc_val
);

    AST_BOOT_VEC: assert property (@(negedge clk)
        rst |=> (rst || (mem_req && mem_rd && mem_addr == RESET_VEC)));          // R1

    AST_WRITE_AT_OPERAND: assert property (@(negedge clk) disable iff (rst)
        (mem_req && !mem_rd) |-> (mem_addr == ir_addr));                        // R4

    AST_WRITE_THEN_FETCH: assert property (@(negedge clk) disable iff (rst)
        (mem_req && !mem_rd) |=> (mem_req && mem_rd));                          // R9

    AST_STOP_HOLDS: assert property (@(negedge clk) disable iff (rst)
        !mem_req |=> !mem_req);                                                 // R8

    AST_FETCH_INCR: assert property (@(negedge clk) disable iff (rst)
        ir_load |=> (pc_val == ($past(mem_addr) + 12'd1)));                     // R10

    AST_PC_HOLD: assert property (@(negedge clk) disable iff (rst)
        !ir_load |=> $stable(pc_val));                                          // R10

endmodule

bind tc_accum_core tc_accum_core_chk #(.RESET_VEC(RESET_VEC)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mem_addr (mem_addr),
    .mem_req  (mem_req),
    .mem_rd   (mem_rd),
    .ir_load  (ir_load),
    .ir_addr  (ir_addr),
    .pc_val   (pc_val)
);

// File: tb/test_tc_accum_core.sv
`timescale 1ns/1ps
module test_tc_accum_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] mem_addr;
    logic [15:0] mem_rdata;
    logic [15:0] mem_wdata;
    logic        mem_req;
    logic        mem_rd;

    always #10 clk = ~clk;

    tc_accum_core i_tc_accum_core (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_req   (mem_req),
        .mem_rd    (mem_rd)
    );

    logic [15:0] mem     [0:255];
    logic [15:0] ref_mem [0:255];

    assign mem_rdata = mem[mem_addr[7:0]];

    always @(negedge clk) begin
        if (!rst && mem_req && !mem_rd) mem[mem_addr[7:0]] <= mem_wdata;
    end

    typedef struct packed {
        logic [11:0] addr;
        logic        rd;
        logic [15:0] data;
    } xact_t;

    xact_t exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    xact_t mon_e;
    string mon_t;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input int op, input int a);
        return {op[3:0], a[11:0]};
    endfunction

    task automatic push(input logic [11:0] a, input logic rd, input logic [15:0] d,
                        input string tag);
        xact_t x;
        x.addr = a; x.rd = rd; x.data = d;
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    task automatic put(input int a, input logic [15:0] w);
        mem[a]     = w;
        ref_mem[a] = w;
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 256; i++) put(i, 16'h0000);
    endtask

    // Instruction-level model of the requirements, produces the expected bus trace
    task automatic run_model();
        logic [11:0] pc;
        logic [15:0] acc;
        logic [15:0] ir;
        logic [3:0]  op;
        logic [11:0] a;
        bit          stop;
        bit          taken;
        string       jt;
        exp_q.delete();
        tag_q.delete();
        push(12'h000, 1'b1, 16'h0, "R1");
        ir = ref_mem[0]; pc = 12'h001; acc = 16'h0; stop = 0;
        for (int s = 0; s < 400 && !stop; s++) begin
            op = ir[15:12]; a = ir[11:0];
            if (op <= 4'd3) begin
                case (op)
                    4'd0: begin push(a, 1'b1, 16'h0, "R2/R3"); acc = ref_mem[a[7:0]]; end
                    4'd1: begin push(a, 1'b0, acc, "R4"); ref_mem[a[7:0]] = acc; end
                    4'd2: begin push(a, 1'b1, 16'h0, "R3"); acc = acc + ref_mem[a[7:0]]; end
                    default: begin push(a, 1'b1, 16'h0, "R3"); acc = acc - ref_mem[a[7:0]]; end
                endcase
                push(pc, 1'b1, 16'h0, "R9/R10");
                ir = ref_mem[pc[7:0]]; pc = pc + 12'd1;
            end else if (op <= 4'd6) begin
                taken = (op == 4'd4) || (op == 4'd5 && !acc[15]) || (op == 4'd6 && acc != 16'h0);
                jt = (op == 4'd4) ? "R5" : (op == 4'd5) ? "R6" : "R7";
                if (taken) begin
                    push(a, 1'b1, 16'h0, jt);
                    ir = ref_mem[a[7:0]]; pc = a + 12'd1;
                end else begin
                    push(pc, 1'b1, 16'h0, jt);
                    ir = ref_mem[pc[7:0]]; pc = pc + 12'd1;
                end
            end else begin
                stop = 1;
            end
        end
    endtask

    // Monitor: compare each live bus cycle against the scoreboard
    always @(posedge clk) begin
        if (!rst && mem_req) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected access at", {20'h0, mem_addr}, 32'h0);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                check(mem_addr == mon_e.addr, mon_t, "address", {20'h0, mem_addr}, {20'h0, mon_e.addr});
                check(mem_rd == mon_e.rd, mon_t, "direction", {31'h0, mem_rd}, {31'h0, mon_e.rd});
                if (!mon_e.rd)
                    check(mem_wdata == mon_e.data, mon_t, "write data", {16'h0, mem_wdata}, {16'h0, mon_e.data});
            end
        end
    end

    task automatic run_prog();
        rst = 1'b1;
        run_model();
        repeat (2) @(negedge clk);
        @(posedge clk); #1;
        check(mem_req && mem_rd && mem_addr == 12'h000, "R1", "reset bus read at 0",
              {19'h0, mem_req, mem_rd, mem_addr}, {19'h0, 1'b1, 1'b1, 12'h000});
        check(mem_wdata == 16'h0, "R1", "accumulator after reset", {16'h0, mem_wdata}, 32'h0);
        @(negedge clk); #2;
        rst = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            if (exp_q.size() == 0 && !mem_req) break;
        end
        check(exp_q.size() == 0, "R9", "expected accesses left", exp_q.size(), 32'h0);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            check(!mem_req, "R8", "request after stop", {31'h0, mem_req}, 32'h0);
        end
    endtask

    task automatic cmp_word(input int a, input logic [15:0] exp, input string req);
        check(mem[a] == exp, req, $sformatf("memory word %0d", a), {16'h0, mem[a]}, {16'h0, exp});
        check(mem[a] == ref_mem[a], req, $sformatf("model word %0d", a), {16'h0, mem[a]}, {16'h0, ref_mem[a]});
    endtask

    task automatic load_countdown();
        clear_mem();
        put(0, enc(0, 30)); put(1, enc(3, 31)); put(2, enc(1, 32));
        put(3, enc(6, 1));  put(4, enc(7, 0));
        put(30, 16'd3); put(31, 16'd1); put(32, 16'hFFFF);
    endtask

    initial begin
        // Arithmetic with wrap
        clear_mem();
        put(0, enc(0, 20)); put(1, enc(2, 21)); put(2, enc(3, 22)); put(3, enc(1, 23));
        put(4, enc(0, 24)); put(5, enc(2, 25)); put(6, enc(1, 26)); put(7, enc(7, 0));
        put(20, 16'd5); put(21, 16'd7); put(22, 16'd3); put(24, 16'hFFFF); put(25, 16'd2);
        run_prog();
        cmp_word(23, 16'd9, "R3");
        cmp_word(26, 16'h0001, "R3");

        // Reset in the middle of a run, then a countdown loop on the non-zero jump
        load_countdown();
        run_model();
        @(negedge clk); #2;
        rst = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk); #2;
        rst = 1'b1;
        exp_q.delete(); tag_q.delete();
        @(negedge clk); #2;
        check(mem_addr == 12'h000 && mem_req && mem_rd, "R1", "bus after mid-run reset",
              {20'h0, mem_addr}, 32'h0);
        load_countdown();
        run_prog();
        cmp_word(32, 16'h0000, "R7");

        // Non-negative jump both ways, unconditional jump
        clear_mem();
        put(0, enc(0, 40)); put(1, enc(5, 5)); put(2, enc(0, 41)); put(3, enc(5, 6));
        put(4, 16'hF000);   put(5, 16'hF000); put(6, enc(1, 42)); put(7, enc(4, 9));
        put(8, 16'hF000);   put(9, enc(0, 43)); put(10, enc(5, 12)); put(11, 16'hF000);
        put(12, enc(1, 44)); put(13, enc(7, 0));
        put(40, 16'h8000); put(41, 16'd5); put(43, 16'h0000); put(44, 16'h1234);
        run_prog();
        cmp_word(42, 16'd5, "R6");
        cmp_word(44, 16'h0000, "R5");

        // Store then execute the stored word
        clear_mem();
        put(0, enc(0, 50)); put(1, enc(1, 2)); put(2, 16'hF000); put(3, enc(1, 52));
        put(4, enc(7, 0));
        put(50, enc(0, 51)); put(51, 16'hABCD);
        run_prog();
        cmp_word(2, enc(0, 51), "R11");
        cmp_word(52, 16'hABCD, "R11");

        // Reserved opcode as first word stops at once
        clear_mem();
        put(0, 16'hB000); put(1, enc(1, 60));
        put(60, 16'h5555);
        run_prog();
        cmp_word(60, 16'h5555, "R8");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule